// File: doc/BRIEF.md
# PWM channel mask and layered write-protection register

This block holds the control state that sits in front of a group of PWM channels. A small byte-wide register bus reaches three locations: a lock register, a channel control register, and a configuration register. The control register carries an acceleration-enable flag and one mask bit per channel. The configuration register carries a two-bit operating-mode field and one swap bit for each channel pair.

Write protection is built in two layers. A sticky global lock, once set, freezes the acceleration-enable flag. That flag in turn decides whether the mode and swap fields accept writes. The mask bits are outside both layers and are always writable. A masked channel's output is held at 0 (zero duty). An unmasked channel passes its PWM input unchanged.

The mode and swap values are brought out as outputs for the downstream swap and mode logic, which is not part of this block. Read data is combinational from the address. Writes take effect on the clock edge that samples the strobe. The asynchronous active-low reset is asserted at once and released through a small synchronizer.

Top module: `pwmwp_top`

## Requirements
- R1: While reset is asserted, and once it is released, the lock reads 0x00, the control register reads 0x40 (enable 0, masks 0), the configuration register reads 0x00, and every channel passes through unmasked.
- R2: Control register (address 1) layout: bit 7 is the acceleration enable, bit 6 always reads 1 and ignores writes, and bits 5:0 are the channel masks (bit n is channel n).
- R3: Lock register (address 0), bit 0: a write with bit 0 = 1 sets the lock. Writes with bit 0 = 0 are ignored. Only reset clears it. It reads back in bit 0, and the other bits read 0.
- R4: While the lock is set, a write to the control register leaves the acceleration-enable bit unchanged.
- R5: While the acceleration enable is 0, writes to the configuration register (address 2) are discarded.
- R6: While the acceleration enable is 1, a configuration write stores bits 5:4 as the mode and bits 2:0 as the pair swaps (bit k is pair k). The new values appear on cfg_mode and cfg_swap after that clock edge.
- R7: A control-register write always updates the mask bits, whatever the state of the lock and the enable.
- R8: pwm_out[n] is 0 while mask bit n is 1, and it equals pwm_in[n] while mask bit n is 0. This holds combinationally, in the same cycle.
- R9: Reading the configuration register returns {2'b00, mode, 1'b0, swap}, whatever the protection state.
- R10: If the enable was set before the lock, it stays at 1 for good, and the configuration remains writable.
- R11: An address other than 0, 1 or 2 reads 0x00, and a write to it changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W (4) | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr |
| pwm_in | input | NCH (6) | Raw PWM channel inputs |
| pwm_out | output | NCH (6) | Channel outputs after masking |
| cfg_mode | output | MODE_W (2) | Stored mode field |
| cfg_swap | output | NCH/2 (3) | Stored pair-swap bits |

## Verification
The bench builds the block with its default parameters. NCH = 6 fills the whole mask field, so every mask bit and every one of the three swap pairs is exercised. A 4-bit address leaves thirteen unmapped locations for the R11 probes. The two-stage reset synchronizer lets the bench check that writes placed before the release completes are dropped. A mid-run reset is also applied, so the clearing of the sticky lock can be checked and the second protection layer can be driven from both orders of enable and lock.

// File: rtl/pwmwp_pkg.sv
package pwmwp_pkg;
  localparam int unsigned DATA_W   = 8;
  localparam int unsigned ACC_BIT  = 7;
  localparam int unsigned RSV_BIT  = 6;
  localparam int unsigned LOCK_BIT = 0;
  localparam int unsigned MODE_LSB = 4;
  typedef logic [DATA_W-1:0] byte_t;
endpackage

// File: rtl/pwmwp_rst_sync.sv
module pwmwp_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_q_n = sync_q[STAGES-1];
endmodule

// File: rtl/pwmwp_ctrl.sv
module pwmwp_ctrl #(
  parameter int unsigned NCH = 6
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           ctrl_we,
  input  logic           lock_set_we,
  input  pwmwp_pkg::byte_t wdata,
  output logic           lock_q,
  output logic           acc_q,
  output logic [NCH-1:0] mask_q
);
  import pwmwp_pkg::*;

  logic           lock_d, acc_d;
  logic           acc_en;
  logic [NCH-1:0] mask_d;

  always_comb begin
    lock_d = lock_q | lock_set_we;
    acc_en = ctrl_we & ~lock_q;
    acc_d  = acc_en ? wdata[ACC_BIT] : acc_q;
    mask_d = ctrl_we ? wdata[NCH-1:0] : mask_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q <= 1'b0;
      acc_q  <= 1'b0;
      mask_q <= '0;
    end else begin
      lock_q <= lock_d;
      acc_q  <= acc_d;
      mask_q <= mask_d;
    end
  end
endmodule

// File: rtl/pwmwp_cfg.sv
module pwmwp_cfg #(
  parameter int unsigned MODE_W = 2,
  parameter int unsigned NPAIR  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic              acc_q,
  input  pwmwp_pkg::byte_t  wdata,
  output logic [MODE_W-1:0] mode_q,
  output logic [NPAIR-1:0]  swap_q
);
  import pwmwp_pkg::*;

  logic              cfg_en;
  logic [MODE_W-1:0] mode_d;
  logic [NPAIR-1:0]  swap_d;

  always_comb begin
    cfg_en = cfg_we & acc_q;
    mode_d = cfg_en ? wdata[MODE_LSB +: MODE_W] : mode_q;
    swap_d = cfg_en ? wdata[NPAIR-1:0] : swap_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      swap_q <= '0;
    end else begin
      mode_q <= mode_d;
      swap_q <= swap_d;
    end
  end
endmodule

// File: rtl/pwmwp_mask.sv
module pwmwp_mask #(
  parameter int unsigned NCH = 6
) (
  input  logic [NCH-1:0] pwm_in,
  input  logic [NCH-1:0] mask_q,
  output logic [NCH-1:0] pwm_out
);
  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    assign pwm_out[ch] = mask_q[ch] ? 1'b0 : pwm_in[ch];
  end
endmodule

// File: rtl/pwmwp_top.sv
module pwmwp_top #(
  parameter int unsigned ADDR_W     = 4,
  parameter int unsigned NCH        = 6,
  parameter int unsigned MODE_W     = 2,
  parameter int unsigned RST_STAGES = 2,
  parameter int unsigned LOCK_ADDR  = 0,
  parameter int unsigned CTRL_ADDR  = 1,
  parameter int unsigned CFG_ADDR   = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic                 bus_wr,
  input  logic [7:0]           bus_wdata,
  output logic [7:0]           bus_rdata,
  input  logic [NCH-1:0]       pwm_in,
  output logic [NCH-1:0]       pwm_out,
  output logic [MODE_W-1:0]    cfg_mode,
  output logic [NCH/2-1:0]     cfg_swap
);
  import pwmwp_pkg::*;

  localparam int unsigned NPAIR = NCH / 2;
  localparam logic [ADDR_W-1:0] A_LOCK = ADDR_W'(LOCK_ADDR);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(CTRL_ADDR);
  localparam logic [ADDR_W-1:0] A_CFG  = ADDR_W'(CFG_ADDR);

  logic           rst_q_n;
  logic           hit_lock, hit_ctrl, hit_cfg;
  logic           lock_set_we, ctrl_we, cfg_we;
  logic           lock_q, acc_q;
  logic [NCH-1:0] mask_q;
  byte_t          rd_mux;

  pwmwp_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_q_n(rst_q_n)
  );

  always_comb begin
    hit_lock    = (bus_addr == A_LOCK);
    hit_ctrl    = (bus_addr == A_CTRL);
    hit_cfg     = (bus_addr == A_CFG);
    lock_set_we = bus_wr & hit_lock & bus_wdata[LOCK_BIT];
    ctrl_we     = bus_wr & hit_ctrl;
    cfg_we      = bus_wr & hit_cfg;
  end

  pwmwp_ctrl #(.NCH(NCH)) u_ctrl (
    .clk(clk), .rst_n(rst_q_n), .ctrl_we(ctrl_we), .lock_set_we(lock_set_we),
    .wdata(bus_wdata), .lock_q(lock_q), .acc_q(acc_q), .mask_q(mask_q)
  );

  pwmwp_cfg #(.MODE_W(MODE_W), .NPAIR(NPAIR)) u_cfg (
    .clk(clk), .rst_n(rst_q_n), .cfg_we(cfg_we), .acc_q(acc_q),
    .wdata(bus_wdata), .mode_q(cfg_mode), .swap_q(cfg_swap)
  );

  pwmwp_mask #(.NCH(NCH)) u_mask (
    .pwm_in(pwm_in), .mask_q(mask_q), .pwm_out(pwm_out)
  );

  always_comb begin
    rd_mux = '0;
    if (hit_lock) begin
      rd_mux[LOCK_BIT] = lock_q;
    end else if (hit_ctrl) begin
      rd_mux[ACC_BIT]   = acc_q;
      rd_mux[RSV_BIT]   = 1'b1;
      rd_mux[NCH-1:0]   = mask_q;
    end else if (hit_cfg) begin
      rd_mux[MODE_LSB +: MODE_W] = cfg_mode;
      rd_mux[NPAIR-1:0]          = cfg_swap;
    end
  end

  assign bus_rdata = rd_mux;
endmodule

// File: rtl/pwmwp_chk.sv
module pwmwp_chk #(
  parameter int unsigned ADDR_W    = 4,
  parameter int unsigned NCH       = 6,
  parameter int unsigned MODE_W    = 2,
  parameter int unsigned CTRL_ADDR = 1,
  parameter int unsigned CFG_ADDR  = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic [7:0]        bus_wdata,
  input logic [7:0]        bus_rdata,
  input logic [NCH-1:0]    pwm_out,
  input logic              lock_q,
  input logic              acc_q,
  input logic [NCH-1:0]    mask_q,
  input logic [MODE_W-1:0] cfg_mode,
  input logic [NCH/2-1:0]  cfg_swap
);
  localparam int unsigned NPAIR = NCH / 2;

  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> lock_q); // R3
  AST_ACC_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> $stable(acc_q)); // R4
  AST_CFG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_q |=> $stable({cfg_mode, cfg_swap})); // R5
  AST_CFG_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_q && bus_wr && bus_addr == ADDR_W'(CFG_ADDR)) |=>
      (cfg_mode == $past(bus_wdata[4 +: MODE_W]) && cfg_swap == $past(bus_wdata[NPAIR-1:0]))); // R6
  AST_MASK_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADDR_W'(CTRL_ADDR)) |=> mask_q == $past(bus_wdata[NCH-1:0])); // R7
  AST_MASKED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (pwm_out & mask_q) == '0); // R8
  AST_RSV_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == ADDR_W'(CTRL_ADDR)) |-> bus_rdata[6]); // R2
endmodule

bind pwmwp_top pwmwp_chk #(
  .ADDR_W(ADDR_W), .NCH(NCH), .MODE_W(MODE_W), .CTRL_ADDR(CTRL_ADDR), .CFG_ADDR(CFG_ADDR)
) u_chk (
  .clk(clk), .rst_n(rst_q_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwm_out(pwm_out),
  .lock_q(lock_q), .acc_q(acc_q), .mask_q(mask_q),
  .cfg_mode(cfg_mode), .cfg_swap(cfg_swap)
);

// File: tb/pwmwp_top_tb.sv
module pwmwp_top_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] bus_addr = '0;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [5:0] pwm_in = '0;
  logic [5:0] pwm_out;
  logic [1:0] cfg_mode;
  logic [2:0] cfg_swap;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // behavioural reference state
  int m_sync = 0;
  bit m_lock = 0, m_acc = 0;
  bit [5:0] m_mask = '0;
  bit [1:0] m_mode = '0;
  bit [2:0] m_swap = '0;

  always #2 clk = ~clk;

  pwmwp_top u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwm_in(pwm_in),
    .pwm_out(pwm_out), .cfg_mode(cfg_mode), .cfg_swap(cfg_swap)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_sync <= 0; m_lock <= 0; m_acc <= 0; m_mask <= '0; m_mode <= '0; m_swap <= '0;
    end else if (m_sync < 2) begin
      m_sync <= m_sync + 1;
    end else if (bus_wr) begin
      case (bus_addr)
        4'd0: if (bus_wdata[0]) m_lock <= 1;
        4'd1: begin
          if (!m_lock) m_acc <= bus_wdata[7];
          m_mask <= bus_wdata[5:0];
        end
        4'd2: if (m_acc) begin
          m_mode <= bus_wdata[5:4];
          m_swap <= bus_wdata[2:0];
        end
        default: ;
      endcase
    end
  end

  function automatic logic [7:0] exp_rd(input logic [3:0] a);
    case (a)
      4'd0: return {7'b0, m_lock};
      4'd1: return {m_acc, 1'b1, m_mask};
      4'd2: return {2'b00, m_mode, 1'b0, m_swap};
      default: return 8'h00;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h at %0t", tag, act, exp, $time);
    end
  endtask

  // drive at negedge, let one posedge pass, compare at the following negedge
  task automatic step(input string tag, input logic [3:0] a, input logic w,
                      input logic [7:0] d, input logic [5:0] p);
    bus_addr = a; bus_wr = w; bus_wdata = d; pwm_in = p;
    @(posedge clk);
    @(negedge clk);
    bus_wr = 1'b0;
    chk(tag, bus_rdata, exp_rd(bus_addr));
    chk("R8", {2'b00, pwm_out}, {2'b00, pwm_in & ~m_mask});
    chk("R6", {3'b000, cfg_mode, cfg_swap}, {3'b000, m_mode, m_swap});
  endtask

  task automatic rd(input string tag, input logic [3:0] a);
    step(tag, a, 1'b0, 8'h00, 6'h2D);
  endtask

  initial begin
    #(4 * 20000);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    rd("R1", 4'd1);
    rd("R1", 4'd0);
    chk("R1", bus_rdata, 8'h00);
    rst_n = 1'b1;
    // writes inside the synchronizer window must be dropped
    step("R1", 4'd1, 1'b1, 8'hBF, 6'h3F);
    rd("R1", 4'd1);
    chk("R1", bus_rdata, 8'h40);
    rd("R1", 4'd2);
    chk("R1", bus_rdata, 8'h00);

    step("R5", 4'd2, 1'b1, 8'h3F, 6'h00);
    chk("R5", bus_rdata, 8'h00);
    step("R2", 4'd1, 1'b1, 8'hFF, 6'h3F);
    chk("R2", bus_rdata, 8'hFF);
    chk("R8", {2'b00, pwm_out}, 8'h00);
    step("R7", 4'd1, 1'b1, 8'h95, 6'h3F);
    chk("R8", {2'b00, pwm_out}, 8'h2A);
    step("R2", 4'd1, 1'b1, 8'h80, 6'h15);
    chk("R2", bus_rdata, 8'hC0);
    step("R6", 4'd2, 1'b1, 8'h25, 6'h3F);
    chk("R6", {6'b0, cfg_mode}, 8'h02);
    chk("R9", bus_rdata, 8'h25);
    step("R6", 4'd2, 1'b1, 8'hDA, 6'h3F);
    chk("R9", bus_rdata, 8'h12);
    step("R2", 4'd1, 1'b1, 8'h00, 6'h0F);
    step("R5", 4'd2, 1'b1, 8'h25, 6'h0F);
    chk("R5", bus_rdata, 8'h12);

    step("R3", 4'd0, 1'b1, 8'hFE, 6'h00);
    chk("R3", bus_rdata, 8'h00);
    step("R2", 4'd1, 1'b1, 8'h80, 6'h00);
    step("R3", 4'd0, 1'b1, 8'h01, 6'h00);
    chk("R3", bus_rdata, 8'h01);
    step("R4", 4'd1, 1'b1, 8'h0A, 6'h3F);
    chk("R4", bus_rdata, 8'hCA);
    step("R10", 4'd2, 1'b1, 8'h13, 6'h3F);
    chk("R10", bus_rdata, 8'h13);
    step("R3", 4'd0, 1'b1, 8'h00, 6'h00);
    chk("R3", bus_rdata, 8'h01);

    step("R11", 4'd5, 1'b1, 8'hFF, 6'h00);
    chk("R11", bus_rdata, 8'h00);
    step("R11", 4'd15, 1'b1, 8'hFF, 6'h00);
    rd("R11", 4'd1);
    chk("R11", bus_rdata, 8'hCA);
    rd("R11", 4'd2);
    chk("R11", bus_rdata, 8'h13);

    // second reset clears the sticky lock
    rst_n = 1'b0;
    rd("R3", 4'd0);
    chk("R3", bus_rdata, 8'h00);
    rst_n = 1'b1;
    rd("R1", 4'd1);
    rd("R1", 4'd1);
    rd("R1", 4'd1);
    step("R3", 4'd0, 1'b1, 8'hFF, 6'h00);
    chk("R3", bus_rdata, 8'h01);
    step("R4", 4'd1, 1'b1, 8'hBF, 6'h3F);
    chk("R4", bus_rdata, 8'h7F);
    step("R7", 4'd1, 1'b1, 8'h81, 6'h3F);
    chk("R7", bus_rdata, 8'h41);
    step("R5", 4'd2, 1'b1, 8'h33, 6'h3F);
    chk("R5", bus_rdata, 8'h00);

    // mixed traffic compared against the model every cycle
    begin
      logic [31:0] lfsr = 32'h1ACE_B00C;
      for (int i = 0; i < 200; i++) begin
        lfsr = lfsr * 32'd1664525 + 32'd1013904223;
        if (i == 100) begin
          rst_n = 1'b0;
          rd("R1", 4'd1);
          rst_n = 1'b1;
        end
        step("R9", lfsr[27:24] & 4'h3, lfsr[20], lfsr[15:8], lfsr[5:0]);
      end
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule